// File: doc/BRIEF.md
# Card Data Buffer with Threshold Requests

This block is the word buffer that sits between a host register interface and a memory-card data engine. It stores 16-bit words in a 32-entry ring. The host pushes words through a data-register write and pulls them through a data-register read. The card engine has its own push and pop strobes. All four sources act on the same ring, and the word at the head is always visible on both read outputs.

A configuration register holds two fill thresholds and one DMA enable per direction. In the receive direction the buffer fills from the card, so the block watches for the fill count rising above the almost-full level. In the transmit direction the buffer drains to the card, so it watches for the fill count falling below the almost-empty level. When the watched condition holds, it drives either that direction's DMA request line or that direction's status flag, depending on the DMA enable. When no transfer is active and the ring is empty, all four outputs are held low.

Top module: `card_data_buffer`

## Requirements
- R1: After reset the fill count is 0, every request and status output is low, and the configuration readback is 16'h1F00 (almost-full level 31, almost-empty level 0, both DMA enables off).
- R2: Words leave the ring in the order they entered it. The head word is shown on both `host_rdata_o` and `card_rdata_o`, and a pop moves the head on by one entry.
- R3: A push while the ring holds 32 words is dropped. The fill count stays at 32 and the stored words are unchanged.
- R4: A pop while the ring is empty leaves the head pointer and the fill count unchanged. The read outputs keep showing the entry at the head.
- R5: The configuration word is laid out as follows: bit 15 is the receive DMA enable, bits 12:8 the almost-full level, bit 7 the transmit DMA enable and bits 4:0 the almost-empty level. All other bits are not stored and read back as 0.
- R6: When the direction is receive (`rx_dir_i`=1) and the fill count is greater than the almost-full level, `rx_req_o` is high if receive DMA is enabled, and `rx_flag_o` is high otherwise. In every other case both are low.
- R7: When the direction is transmit (`rx_dir_i`=0) and the fill count is less than the almost-empty level, `tx_req_o` is high if transmit DMA is enabled, and `tx_flag_o` is high otherwise. In every other case both are low.
- R8: When `xfer_active_i` is low and the ring is empty, all four request and status outputs go low at the next edge.
- R9: A configuration write with a DMA enable bit set clears that direction's status flag at the same clock edge.
- R10: The request and status outputs are registered. They reflect a new fill count or configuration one clock edge after the edge that changed it.
- R11: A push and a pop in the same cycle on a ring that is neither empty nor full leave the fill count unchanged and keep the word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host data-register write (push) |
| host_wdata_i | input | 16 | Host push data |
| host_rd_i | input | 1 | Host data-register read (pop) |
| host_rdata_o | output | 16 | Head word for the host |
| cfg_wr_i | input | 1 | Configuration register write |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_o | output | 16 | Configuration readback |
| card_push_i | input | 1 | Card-side push |
| card_wdata_i | input | 16 | Card-side push data |
| card_pop_i | input | 1 | Card-side pop |
| card_rdata_o | output | 16 | Head word for the card side |
| xfer_active_i | input | 1 | A data transfer is in progress |
| rx_dir_i | input | 1 | 1 = receive (card to host), 0 = transmit |
| fill_o | output | 6 | Words currently held (0 to 32) |
| rx_req_o | output | 1 | Receive DMA request |
| tx_req_o | output | 1 | Transmit DMA request |
| rx_flag_o | output | 1 | Receive threshold status flag |
| tx_flag_o | output | 1 | Transmit threshold status flag |

## Verification
The assertions assume that at most one push source and at most one pop source are active in any cycle: a host write never coincides with a card push, and a host read never coincides with a card pop. The direction and transfer-active inputs are also assumed to change only between operations. The bench drives each scenario from a single side at a time. The only exception is the concurrent case, which pairs a host write with a card pop. Every input is changed on the falling edge, so each strobe lasts exactly one rising edge.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int LVL_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  // field positions decoded by software
  localparam int RX_EN_BIT = 15;
  localparam int AF_LSB    = 8;
  localparam int TX_EN_BIT = 7;
  localparam int AE_LSB    = 0;

  typedef struct packed {
    logic             rx_en;
    logic [LVL_W-1:0] af_lvl;
    logic             tx_en;
    logic [LVL_W-1:0] ae_lvl;
  } buf_cfg_t;
endpackage

// File: rtl/cdb_ring.sv
module cdb_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CW-1:0]     fill_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     head_q;
  logic [CW-1:0]     fill_q;
  logic [AW-1:0]     tail;
  logic              do_push, do_pop;

  assign do_push = push_i && (fill_q != CW'(DEPTH));
  assign do_pop  = pop_i && (fill_q != '0);
  assign tail    = head_q + fill_q[AW-1:0];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[tail] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      fill_q <= '0;
    end else begin
      if (do_pop) head_q <= head_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  assign head_o = mem_q[head_q];
  assign fill_o = fill_q;

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= CW'(DEPTH));
  assert_full_push_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == CW'(DEPTH) && push_i && !pop_i) |=> $stable(fill_q));
  assert_empty_pop_inert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == '0 && pop_i && !push_i) |=> ($stable(head_q) && fill_q == '0));
  assert_push_pop_balance_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && fill_q != '0 && fill_q != CW'(DEPTH)) |=> $stable(fill_q));
endmodule

// File: rtl/cdb_cfg.sv
module cdb_cfg
  import cdb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [15:0]   wdata_i,
  output buf_cfg_t      cfg_o,
  output logic [15:0]   rdata_o
);
  buf_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.rx_en  <= 1'b0;
      cfg_q.af_lvl <= '1;
      cfg_q.tx_en  <= 1'b0;
      cfg_q.ae_lvl <= '0;
    end else if (wr_i) begin
      cfg_q.rx_en  <= wdata_i[RX_EN_BIT];
      cfg_q.af_lvl <= wdata_i[AF_LSB +: LVL_W];
      cfg_q.tx_en  <= wdata_i[TX_EN_BIT];
      cfg_q.ae_lvl <= wdata_i[AE_LSB +: LVL_W];
    end
  end

  always_comb begin
    rdata_o                   = '0;
    rdata_o[RX_EN_BIT]        = cfg_q.rx_en;
    rdata_o[AF_LSB +: LVL_W]  = cfg_q.af_lvl;
    rdata_o[TX_EN_BIT]        = cfg_q.tx_en;
    rdata_o[AE_LSB +: LVL_W]  = cfg_q.ae_lvl;
  end

  assign cfg_o = cfg_q;

  assert_cfg_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (rdata_o == ($past(wdata_i) & 16'h9F9F)));
endmodule

// File: rtl/cdb_level_mon.sv
module cdb_level_mon
  import cdb_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] fill_i,
  input  buf_cfg_t      cfg_i,
  input  logic          xfer_active_i,
  input  logic          rx_dir_i,
  input  logic          cfg_wr_i,
  input  logic          new_rx_en_i,
  input  logic          new_tx_en_i,
  output logic          rx_req_o,
  output logic          tx_req_o,
  output logic          rx_flag_o,
  output logic          tx_flag_o
);
  logic idle, rx_hit, tx_hit;
  logic rx_req_q, tx_req_q, rx_flag_q, tx_flag_q;

  assign idle   = !xfer_active_i && (fill_i == '0);
  assign rx_hit = !idle && rx_dir_i && (fill_i > CW'(cfg_i.af_lvl));
  assign tx_hit = !idle && !rx_dir_i && (fill_i < CW'(cfg_i.ae_lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_req_q  <= 1'b0;
      tx_req_q  <= 1'b0;
      rx_flag_q <= 1'b0;
      tx_flag_q <= 1'b0;
    end else begin
      rx_req_q  <= rx_hit && cfg_i.rx_en;
      tx_req_q  <= tx_hit && cfg_i.tx_en;
      // enabling DMA on a direction retires its flag at the write edge
      rx_flag_q <= rx_hit && !cfg_i.rx_en && !(cfg_wr_i && new_rx_en_i);
      tx_flag_q <= tx_hit && !cfg_i.tx_en && !(cfg_wr_i && new_tx_en_i);
    end
  end

  assign rx_req_o  = rx_req_q;
  assign tx_req_o  = tx_req_q;
  assign rx_flag_o = rx_flag_q;
  assign tx_flag_o = tx_flag_q;

  assert_rx_req_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_active_i && rx_dir_i && fill_i > CW'(cfg_i.af_lvl) && cfg_i.rx_en) |=> rx_req_o);
  assert_rx_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.rx_en |=> !rx_req_o);
  assert_tx_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.tx_en |=> !tx_req_o);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_active_i && fill_i == '0) |=> !(rx_req_o || tx_req_o || rx_flag_o || tx_flag_o));
  assert_rx_flag_retire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && new_rx_en_i) |=> !rx_flag_o);
  assert_tx_flag_retire_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && new_tx_en_i) |=> !tx_flag_o);
endmodule

// File: rtl/card_data_buffer.sv
module card_data_buffer
  import cdb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_rd_i,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              cfg_wr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_o,
  input  logic              card_push_i,
  input  logic [DATA_W-1:0] card_wdata_i,
  input  logic              card_pop_i,
  output logic [DATA_W-1:0] card_rdata_o,
  input  logic              xfer_active_i,
  input  logic              rx_dir_i,
  output logic [CNT_W-1:0]  fill_o,
  output logic              rx_req_o,
  output logic              tx_req_o,
  output logic              rx_flag_o,
  output logic              tx_flag_o
);
  logic              push, pop;
  logic [DATA_W-1:0] pdata, head;
  logic [CNT_W-1:0]  fill;
  buf_cfg_t          cfg;

  assign push  = host_wr_i || card_push_i;
  assign pop   = host_rd_i || card_pop_i;
  assign pdata = host_wr_i ? host_wdata_i : card_wdata_i;

  cdb_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk_i, .rst_ni,
    .push_i (push),
    .pdata_i(pdata),
    .pop_i  (pop),
    .head_o (head),
    .fill_o (fill)
  );

  cdb_cfg u_cfg (
    .clk_i, .rst_ni,
    .wr_i   (cfg_wr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg),
    .rdata_o(cfg_o)
  );

  cdb_level_mon #(.CW(CNT_W)) u_mon (
    .clk_i, .rst_ni,
    .fill_i       (fill),
    .cfg_i        (cfg),
    .xfer_active_i,
    .rx_dir_i,
    .cfg_wr_i,
    .new_rx_en_i  (cfg_wdata_i[RX_EN_BIT]),
    .new_tx_en_i  (cfg_wdata_i[TX_EN_BIT]),
    .rx_req_o,
    .tx_req_o,
    .rx_flag_o,
    .tx_flag_o
  );

  assign host_rdata_o = head;
  assign card_rdata_o = head;
  assign fill_o       = fill;

  assert_one_push_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_wr_i && card_push_i));
  assert_one_pop_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd_i && card_pop_i));
endmodule

// File: tb/sim_card_data_buffer.sv
`timescale 1ns/1ps
module sim_card_data_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0, cfg_wr = 0, card_push = 0, card_pop = 0;
  logic xfer = 0, rx_dir = 0;
  logic [15:0] host_wdata = 0, cfg_wdata = 0, card_wdata = 0;
  logic [15:0] host_rdata, card_rdata, cfg_rd;
  logic [5:0]  fill;
  logic rx_req, tx_req, rx_flag, tx_flag;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  card_data_buffer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg_rd),
    .card_push_i(card_push), .card_wdata_i(card_wdata), .card_pop_i(card_pop), .card_rdata_o(card_rdata),
    .xfer_active_i(xfer), .rx_dir_i(rx_dir), .fill_o(fill),
    .rx_req_o(rx_req), .tx_req_o(tx_req), .rx_flag_o(rx_flag), .tx_flag_o(tx_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outputs as {rx_req, rx_flag, tx_req, tx_flag}
  function automatic logic [3:0] outs();
    return {rx_req, rx_flag, tx_req, tx_flag};
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic hpush(input logic [15:0] d);
    host_wr = 1; host_wdata = d; tick(); host_wr = 0;
  endtask
  task automatic cpush(input logic [15:0] d);
    card_push = 1; card_wdata = d; tick(); card_push = 0;
  endtask
  task automatic cpop(); card_pop = 1; tick(); card_pop = 0; endtask
  task automatic hpop(); host_rd = 1; tick(); host_rd = 0; endtask
  task automatic cfgw(input logic [15:0] d);
    cfg_wr = 1; cfg_wdata = d; tick(); cfg_wr = 0;
  endtask
  task automatic drain(); while (fill != 0) cpop(); tick(); endtask

  task automatic t_reset();
    chk("R1 fill", fill, 0);
    chk("R1 cfg", cfg_rd, 16'h1F00);
    chk("R1 outs", outs(), 4'b0000);
  endtask

  task automatic t_cfg();
    cfgw(16'h8A85);
    chk("R5 cfg fields", cfg_rd, 16'h8A85);
    cfgw(16'hFFFF);
    chk("R5 unused bits zero", cfg_rd, 16'h9F9F);
    cfgw(16'h1F00);
  endtask

  task automatic t_order();
    hpush(16'hA001); hpush(16'hA002); hpush(16'hA003);
    chk("R2 fill", fill, 3);
    chk("R2 head host", host_rdata, 16'hA001);
    cpop(); chk("R2 second", card_rdata, 16'hA002);
    cpop(); chk("R2 third", card_rdata, 16'hA003);
    cpop(); chk("R2 drained", fill, 0);
    tick();
  endtask

  task automatic t_rx();
    xfer = 1; rx_dir = 1;
    cfgw(16'h0200);            // af=2, rx dma off
    cpush(16'h1); cpush(16'h2);
    tick();
    chk("R6 at level no hit", outs(), 4'b0000);
    cpush(16'h3);              // fill 3 > 2
    chk("R10 one-cycle lag", outs(), 4'b0000);
    tick();
    chk("R6 rx flag", outs(), 4'b0100);
    cfgw(16'h8200);            // enable rx dma
    chk("R9 rx flag cleared", rx_flag, 1'b0);
    tick();
    chk("R6 rx dma request", outs(), 4'b1000);
    cpop(); tick();
    chk("R6 rx drop below", outs(), 4'b0000);
    drain();
  endtask

  task automatic t_tx();
    xfer = 1; rx_dir = 0;
    cfgw(16'h0003);            // ae=3, tx dma off
    tick();
    chk("R7 tx flag empty", outs(), 4'b0001);
    hpush(16'h11); hpush(16'h12); hpush(16'h13); tick();
    chk("R7 at level no hit", outs(), 4'b0000);
    cpop(); tick();
    chk("R7 below level", outs(), 4'b0001);
    cfgw(16'h0083);
    chk("R9 tx flag cleared", tx_flag, 1'b0);
    tick();
    chk("R7 tx dma request", outs(), 4'b0010);
    drain();
  endtask

  task automatic t_idle();
    rx_dir = 0; cfgw(16'h0003);
    xfer = 0; tick(); tick();
    chk("R8 idle quiet", outs(), 4'b0000);
    xfer = 1; tick(); tick();
    chk("R8 active contrast", outs(), 4'b0001);
    xfer = 0; tick(); tick();
    chk("R8 idle again", outs(), 4'b0000);
    cfgw(16'h1F00);
  endtask

  task automatic t_full();
    logic [15:0] first;
    first = 16'h0100;
    for (int i = 0; i < 32; i++) hpush(16'h0100 + 16'(i * 7));
    chk("R3 full", fill, 32);
    hpush(16'hDEAD);
    chk("R3 dropped fill", fill, 32);
    chk("R3 head kept", host_rdata, first);
    for (int i = 0; i < 32; i++) begin
      if (card_rdata !== 16'h0100 + 16'(i * 7)) chk("R3 content", card_rdata, 16'h0100 + 16'(i * 7));
      cpop();
    end
    chk("R3 content all", fill, 0);
    chk("R4 empty head", host_rdata, first);
    hpop();
    chk("R4 fill kept", fill, 0);
    chk("R4 head kept", host_rdata, first);
    hpush(16'h1234);
    chk("R4 pointer kept", host_rdata, 16'h1234);
    drain();
  endtask

  task automatic t_concurrent();
    hpush(16'hB001); hpush(16'hB002);
    host_wr = 1; host_wdata = 16'hB003; card_pop = 1; tick();
    host_wr = 0; card_pop = 0;
    chk("R11 fill", fill, 2);
    chk("R11 head", card_rdata, 16'hB002);
    cpop(); chk("R11 tail", card_rdata, 16'hB003);
    drain();
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_n = 1; tick();
        t_reset();
        t_cfg();
        t_order();
        t_rx();
        t_tx();
        t_idle();
        t_full();
        t_concurrent();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule